// File: doc/BRIEF.md
# Cascaded Modulo-193 Counter

The block counts modulo 193 (by default) on every enabled clock, using a chain of identical 4-bit synchronous counter slices joined through their carry outputs. With the default two slices the chain is an 8-bit binary counter with a natural range of 0 to 255. A mode input picks one of two ways of shortening that range to the modulus, and a terminal-count flag marks the last state of each cycle.

In clear mode the chain runs from 0 up to MODULUS−1 (192). On the enabled clock that leaves 192 it returns to 0 through a synchronous clear. The top state is found by a partial AND, which looks only at the bits that are 1 in 192 (bits 7 and 6). In preset mode the chain runs from 2^8−MODULUS (63) up to 255. On the enabled clock that leaves 255 it reloads 63 through a synchronous parallel load, which the carry out of the top slice triggers. Each slice gives clear priority over load, and load priority over counting. A slice counts only when both of its enables are high.

A small controller picks one chain action for each clock. The four actions are CH_CLEAR, CH_LOAD, CH_RUN and CH_IDLE. Transitions: reset low selects CH_CLEAR in clear mode and CH_LOAD in preset mode. Enable low selects CH_IDLE. A top-state hit in clear mode selects CH_CLEAR. A carry out of the last slice in preset mode selects CH_LOAD. All other cases select CH_RUN. Inside each slice the matching per-slice actions are ACT_CLEAR, ACT_LOAD, ACT_COUNT and ACT_HOLD. The mode input is expected to change only while reset is low.

Top module: `cmod_counter`

## Requirements
- R1: Reset is synchronous and active low. One clock edge with rst_n low gives count 0 in clear mode (mode=0) or count 63 in preset mode (mode=1), and tc reads 0.
- R2: In clear mode (mode=0) with en=1, count rises by exactly 1 on each clock from 0 to 192. The clock after 192 gives 0, so the period is 193 clocks.
- R3: In preset mode (mode=1) with en=1, count rises by exactly 1 on each clock from 63 to 255. The clock after 255 gives 63, so the period is 193 clocks.
- R4: A clock with en=0 and rst_n=1 leaves count unchanged in both modes, including at the terminal states 192 and 255.
- R5: tc is 1 exactly while count is 192 in clear mode, or 255 in preset mode. With en=1, tc is therefore high on exactly one clock in each 193.
- R6: The upper nibble count[7:4] changes on an enabled clock only when the lower nibble count[3:0] was 15 before that clock, or when the clock is a clear-mode wrap from 192.
- R7: In clear mode, an enabled clock from any count above 192 gives 0. This can happen after a switch from preset mode without reset, and it comes from the partial AND on bits 7 and 6.
- R8: After reset in clear mode, count never goes above 192 while the mode stays in clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to the mode's start value |
| mode | input | 1 | 0 = clear mode (0..192), 1 = preset mode (63..255) |
| en | input | 1 | Count enable; 0 holds the count |
| count | output | 8 | Current count of the slice chain |
| tc | output | 1 | Terminal-count flag for the current mode |

## Verification
A wrong slice state, or a wrong chain action, shows on count at the first clock after the fault, because every slice bit is a port bit. Each enabled clock is compared with an independent next-value model, so a skipped or doubled step is caught at once. A faulty carry between the slices shows as a wrong upper nibble on the first crossing from 15 to 0 in the lower nibble, which happens within 16 clocks. A wrong clear or preload decision shows at the wrap, within one 193-clock period, as a wrong value after 192 or 255 and as a wrong count of tc pulses.

// File: rtl/cmod_pkg.sv
package cmod_pkg;

    typedef enum logic {
        MODE_CLEAR  = 1'b0,
        MODE_PRESET = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_COUNT
    } act_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_CLEAR,
        CH_LOAD,
        CH_RUN
    } chain_e;

endpackage

// File: rtl/cmod_stage.sv
module cmod_stage
    import cmod_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         carry
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] q_r;
    act_e         act;

    // priority: clear, then load, then count
    always_comb begin
        if (!clr_n)
            act = ACT_CLEAR;
        else if (!load_n)
            act = ACT_LOAD;
        else if (en_p && en_t)
            act = ACT_COUNT;
        else
            act = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: q_r <= '0;
            ACT_LOAD:  q_r <= d;
            ACT_COUNT: q_r <= q_r + 1'b1;
            ACT_HOLD:  q_r <= q_r;
            default:   q_r <= q_r;
        endcase
    end

    always_comb begin
        q     = q_r;
        carry = (q_r == ALL_ONES) && en_t;
    end

endmodule

// File: rtl/cmod_term.sv
module cmod_term #(
    parameter int W     = 8,
    parameter int VALUE = 192
) (
    input  logic [W-1:0] value_i,
    output logic         hit_o
);

    localparam logic [W-1:0] MASK = W'(VALUE);

    logic [W-1:0] term;

    // only the 1-bits of VALUE take part in the AND
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (MASK[b]) begin : g_used
            assign term[b] = value_i[b];
        end else begin : g_free
            assign term[b] = 1'b1;
        end
    end

    assign hit_o = &term;

endmodule

// File: rtl/cmod_ctrl.sv
module cmod_ctrl
    import cmod_pkg::*;
(
    input  logic rst_n,
    input  logic mode,
    input  logic en,
    input  logic clr_hit,
    input  logic top_carry,
    output logic clr_n,
    output logic load_n,
    output logic en_p
);

    mode_e  mode_v;
    chain_e act;

    assign mode_v = mode_e'(mode);

    always_comb begin
        if (!rst_n)
            act = (mode_v == MODE_CLEAR) ? CH_CLEAR : CH_LOAD;
        else if (!en)
            act = CH_IDLE;
        else if (mode_v == MODE_CLEAR && clr_hit)
            act = CH_CLEAR;
        else if (mode_v == MODE_PRESET && top_carry)
            act = CH_LOAD;
        else
            act = CH_RUN;
    end

    always_comb begin
        clr_n  = 1'b1;
        load_n = 1'b1;
        en_p   = 1'b0;
        unique case (act)
            CH_CLEAR: clr_n  = 1'b0;
            CH_LOAD:  load_n = 1'b0;
            CH_RUN:   en_p   = 1'b1;
            CH_IDLE:  en_p   = 1'b0;
            default:  en_p   = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmod_counter.sv
module cmod_counter
    import cmod_pkg::*;
#(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2,
    parameter int MODULUS = 193
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode,
    input  logic                       en,
    output logic [STAGE_W*STAGES-1:0]  count,
    output logic                       tc
);

    localparam int CW         = STAGE_W * STAGES;
    localparam int TOP_VAL    = MODULUS - 1;
    localparam int FULL_VAL   = (2 ** CW) - 1;
    localparam int PRESET_VAL = (2 ** CW) - MODULUS;
    localparam logic [CW-1:0] PRESET_BITS = CW'(PRESET_VAL);
    localparam logic [CW-1:0] TOP_BITS    = CW'(TOP_VAL);
    localparam logic [CW-1:0] START_BITS  = CW'(PRESET_VAL);
    localparam logic [STAGE_W-1:0] NIB_ONES = {STAGE_W{1'b1}};

    logic [STAGES:0] chain;
    logic [CW-1:0]   q_all;
    logic            clr_n, load_n, en_p;
    logic            clr_hit, full_hit;

    assign chain[0] = 1'b1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        cmod_stage #(.W(STAGE_W)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (en_p),
            .en_t   (chain[i]),
            .d      (PRESET_BITS[i*STAGE_W +: STAGE_W]),
            .q      (q_all[i*STAGE_W +: STAGE_W]),
            .carry  (chain[i+1])
        );
    end

    cmod_term #(.W(CW), .VALUE(TOP_VAL)) u_top_det (
        .value_i (q_all),
        .hit_o   (clr_hit)
    );

    cmod_term #(.W(CW), .VALUE(FULL_VAL)) u_full_det (
        .value_i (q_all),
        .hit_o   (full_hit)
    );

    cmod_ctrl u_ctrl (
        .rst_n     (rst_n),
        .mode      (mode),
        .en        (en),
        .clr_hit   (clr_hit),
        .top_carry (chain[STAGES]),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .en_p      (en_p)
    );

    assign count = q_all;
    assign tc    = (mode_e'(mode) == MODE_CLEAR) ? clr_hit : full_hit;

    // ---------------- assertions ----------------

    p_clear_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 1'b0 && en && count < TOP_BITS) |=> count == CW'($past(count) + 1'b1));

    p_clear_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 1'b0 && en && count == TOP_BITS) |=> count == '0);

    p_preset_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 1'b1 && en && count >= START_BITS && count != {CW{1'b1}})
        |=> count == CW'($past(count) + 1'b1));

    p_preset_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 1'b1 && en && count == {CW{1'b1}}) |=> count == START_BITS);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    p_tc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && en && $stable(mode)) |=> !tc);

    p_upper_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count[STAGE_W-1:0] != NIB_ONES && !(mode == 1'b0 && tc))
        |=> $stable(count[CW-1:STAGE_W]));

    p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 1'b0 && en && count > TOP_BITS) |=> count == '0);

    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 1'b0 && $past(mode) == 1'b0 && $past(count) <= TOP_BITS) |-> count <= TOP_BITS);

endmodule

// File: tb/sim_cmod_counter.sv
`timescale 1ns/1ps
module sim_cmod_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       en = 1'b0;
    logic [7:0] count;
    logic       tc;

    always #5 clk = ~clk;

    cmod_counter u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .en    (en),
        .count (count),
        .tc    (tc)
    );

    int    checks = 0;
    int    failures = 0;
    int    tc_seen = 0;
    int    model = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    // driver: set inputs, predict next count, push to scoreboard
    task automatic step(input bit r, input bit m, input bit e, input string tag);
        @(negedge clk);
        rst_n = r;
        mode  = m;
        en    = e;
        if (!r)
            model = m ? 63 : 0;
        else if (!e)
            model = model;
        else if (!m)
            model = (model >= 192) ? 0 : model + 1;
        else
            model = (model == 255) ? 63 : model + 1;
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        #1;
    endtask

    task automatic check_int(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: pop and compare after each rising edge
    always @(posedge clk) begin
        int    e;
        string t;
        bit    et;
        #2;
        if (exp_q.size() > 0) begin
            e  = exp_q.pop_front();
            t  = tag_q.pop_front();
            et = mode ? (e == 255) : (e == 192);
            checks++;
            if (count !== 8'(e) || tc !== et) begin
                failures++;
                $display("FAIL %s count=%0d tc=%0b expected count=%0d tc=%0b",
                         t, count, tc, e, et);
            end
            if (tc === 1'b1) tc_seen++;
        end
    end

    initial begin
        int snap;
        // R1 reset, clear mode
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R1 reset clear");
        // R2 R5 two full periods
        drain();
        snap = tc_seen;
        for (int i = 0; i < 386; i++) step(1'b1, 1'b0, 1'b1, "R2 R6 clear run");
        drain();
        check_int("R5 clear tc per 386", tc_seen - snap, 2);
        // R4 hold at terminal 192
        for (int i = 0; i < 192; i++) step(1'b1, 1'b0, 1'b1, "R2 to top");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R4 hold at 192");
        step(1'b1, 1'b0, 1'b1, "R2 wrap after hold");
        // R4 R6 alternating enable across nibble borders
        for (int i = 0; i < 80; i++) step(1'b1, 1'b0, i[0], "R4 R6 alt enable");
        // R1 reset, preset mode
        for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b1, "R1 reset preset");
        drain();
        snap = tc_seen;
        for (int i = 0; i < 386; i++) step(1'b1, 1'b1, 1'b1, "R3 R6 preset run");
        drain();
        check_int("R5 preset tc per 386", tc_seen - snap, 2);
        // R4 hold at 255
        for (int i = 0; i < 192; i++) step(1'b1, 1'b1, 1'b1, "R3 to top");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R4 hold at 255");
        step(1'b1, 1'b1, 1'b1, "R3 reload after hold");
        // R7 recovery from above 192 in clear mode
        for (int i = 0; i < 137; i++) step(1'b1, 1'b1, 1'b1, "R3 to 200");
        step(1'b1, 1'b0, 1'b1, "R7 recover from 200");
        // R8 run clear mode after recovery
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b1, "R8 clear range");
        drain();
        check_int("R8 final count", int'(count), 200 % 193);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule